// File: doc/BRIEF.md
# Adapter reset and bring-up sequencer

This block steps a network adapter's glue-logic control registers through three fixed procedures. It owns three registers. The reset register holds three active-low release bits, one each for the core chip, the host interface and the FIFO. The interrupt-control register holds two enables. The FIFO-threshold register holds a byte. The register contents are driven straight onto output ports.

A command arrives as a single-cycle pulse on one of three inputs: enable, full init or close. Each command runs an ordered list of register writes with timed waits in between, then pulses `done`.

A timed wait is counted in time units. One unit is `TICKS_PER_UNIT` clock cycles, and a wait lasts `WAIT_UNITS` units, so a wait is W = `TICKS_PER_UNIT` × `WAIT_UNITS` cycles. With the defaults W is 400. The sequencer accepts a new command only when it is idle.

Top module: `adapter_bringup_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rst_reg`, `irq_en` and `fifo_thr` are zero, and `busy` and `done` are low.
- R2: An enable command sets only `rst_reg[0]` (core chip) and keeps bits 1 and 2 at their prior values. `irq_en` and `fifo_thr` are unchanged. `done` rises W+1 clock edges after the edge that samples the command.
- R3: A full init command first sets `rst_reg[0]`. In the next register update it clears bits 0, 1 and 2 together, so `rst_reg` reads 0.
- R4: During init, `rst_reg` stays at 0 for exactly W+1 cycles after the clearing write. These are the W-cycle wait plus the cycle of the first release step.
- R5: After the wait, the release bits are set one per cycle in a fixed order. The core chip (bit 0) goes first, then the host interface (bit 1), then the FIFO (bit 2). `rst_reg` therefore reads 1, then 3, then 7.
- R6: Only after `rst_reg` reads 7 is `irq_en` written to 2'b11. Bit 0 is the service-interrupt enable and bit 1 is the bus-error enable.
- R7: The last init write sets `fifo_thr` to `THR_VAL` (default 30). `done` rises W+7 edges after the command is sampled.
- R8: A close command writes 0 to `rst_reg` and leaves `irq_en` and `fifo_thr` unchanged. `done` rises 1 edge after the command is sampled.
- R9: A command pulse that arrives while `busy` is high is ignored. It produces no register change and no extra `done`.
- R10: `busy` is high from the edge that accepts a command until the sequence ends. `done` is high for exactly one cycle per accepted command, and only while `busy` is high.
- R11: When several commands pulse in the same idle cycle, close wins over init, and init wins over enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_enable | input | 1 | Pulse: release core chip only |
| cmd_init | input | 1 | Pulse: full bring-up sequence |
| cmd_close | input | 1 | Pulse: force every block into reset |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| rst_reg | output | 3 | Release bits: [0] core, [1] host interface, [2] FIFO; 1 = running |
| irq_en | output | 2 | [0] service interrupt enable, [1] bus-error enable |
| fifo_thr | output | THR_W | FIFO threshold value |

## Verification
Init runs in two contexts. From an all-zero reset register, the preliminary core set shows up as its own step before the clear. From a fully released register, that set is invisible, which separates a sequencer that always clears from one that does not.

Enable runs both on a cleared register and on a fully released one, which shows whether the host-interface and FIFO bits are preserved. The bench records every value the reset register takes and the cycle of each change, so it can see ordering errors, merged release steps and a wrong wait length.

Extra pulses during a running init, and combined pulses while idle, probe the command filter and the close-over-init-over-enable priority.

// File: rtl/brs_pkg.sv
package brs_pkg;

   localparam int RB_CORE = 0;
   localparam int RB_HOST = 1;
   localparam int RB_FIFO = 2;
   localparam int RST_W   = 3;

   localparam int IE_SVC    = 0;
   localparam int IE_BUSERR = 1;
   localparam int IE_W      = 2;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_EN_SET,
      ST_EN_WAIT,
      ST_IN_SET,
      ST_IN_CLR,
      ST_IN_WAIT,
      ST_IN_REL_CORE,
      ST_IN_REL_HOST,
      ST_IN_REL_FIFO,
      ST_IN_IRQ,
      ST_IN_THR,
      ST_CL_ZERO,
      ST_FINISH
   } seq_state_t;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_SET_CORE,
      OP_CLR_ALL,
      OP_REL_HOST,
      OP_REL_FIFO,
      OP_IRQ,
      OP_THR,
      OP_ZERO
   } reg_op_t;

endpackage

// File: rtl/brs_wait_timer.sv
module brs_wait_timer #(
   parameter int TICKS_PER_UNIT = 4,
   parameter int WAIT_UNITS     = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int UW = (WAIT_UNITS > 1) ? $clog2(WAIT_UNITS) : 1;
   localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
   localparam logic [UW-1:0] U_LAST = UW'(WAIT_UNITS - 1);
   localparam logic [PW-1:0] P_LAST = PW'(TICKS_PER_UNIT - 1);

   logic [UW-1:0] ucnt;
   logic          unit_last;

   assign unit_last = (ucnt == U_LAST);

   generate
      if (TICKS_PER_UNIT == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ucnt <= '0;
            else if (!run)       ucnt <= '0;
            else if (unit_last)  ucnt <= '0;
            else                 ucnt <= ucnt + 1'b1;
         end
         assign expire = run & unit_last;
      end else begin : g_prescaled
         logic [PW-1:0] pcnt;
         logic          tick_last;
         assign tick_last = (pcnt == P_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pcnt <= '0;
               ucnt <= '0;
            end else if (!run) begin
               pcnt <= '0;
               ucnt <= '0;
            end else if (tick_last) begin
               pcnt <= '0;
               ucnt <= unit_last ? '0 : ucnt + 1'b1;
            end else begin
               pcnt <= pcnt + 1'b1;
            end
         end
         assign expire = run & tick_last & unit_last;
      end
   endgenerate

endmodule

// File: rtl/brs_ctrl_regs.sv
module brs_ctrl_regs
   import brs_pkg::*;
#(
   parameter int THR_W   = 8,
   parameter int THR_VAL = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_op_t           op,
   output logic [RST_W-1:0]  rst_q,
   output logic [IE_W-1:0]   irq_q,
   output logic [THR_W-1:0]  thr_q
);
   localparam logic [IE_W-1:0] IRQ_ON =
      IE_W'((1 << IE_SVC) | (1 << IE_BUSERR));
   localparam logic [THR_W-1:0] THR_K = THR_W'(THR_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q <= '0;
         irq_q <= '0;
         thr_q <= '0;
      end else begin
         case (op)
            OP_SET_CORE: rst_q[RB_CORE] <= 1'b1;
            OP_CLR_ALL: begin
               rst_q[RB_CORE] <= 1'b0;
               rst_q[RB_HOST] <= 1'b0;
               rst_q[RB_FIFO] <= 1'b0;
            end
            OP_REL_HOST: rst_q[RB_HOST] <= 1'b1;
            OP_REL_FIFO: rst_q[RB_FIFO] <= 1'b1;
            OP_IRQ:      irq_q <= IRQ_ON;
            OP_THR:      thr_q <= THR_K;
            OP_ZERO:     rst_q <= '0;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/brs_seq_fsm.sv
module brs_seq_fsm
   import brs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cmd_enable,
   input  logic    cmd_init,
   input  logic    cmd_close,
   input  logic    expire,
   output reg_op_t op,
   output logic    run,
   output logic    busy,
   output logic    done
);
   seq_state_t st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d = st_q;
      op   = OP_NONE;
      run  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (cmd_close)       st_d = ST_CL_ZERO;
            else if (cmd_init)   st_d = ST_IN_SET;
            else if (cmd_enable) st_d = ST_EN_SET;
         end
         ST_EN_SET: begin
            op   = OP_SET_CORE;
            st_d = ST_EN_WAIT;
         end
         ST_EN_WAIT: begin
            run = 1'b1;
            if (expire) st_d = ST_FINISH;
         end
         ST_IN_SET: begin
            op   = OP_SET_CORE;
            st_d = ST_IN_CLR;
         end
         ST_IN_CLR: begin
            op   = OP_CLR_ALL;
            st_d = ST_IN_WAIT;
         end
         ST_IN_WAIT: begin
            run = 1'b1;
            if (expire) st_d = ST_IN_REL_CORE;
         end
         ST_IN_REL_CORE: begin
            op   = OP_SET_CORE;
            st_d = ST_IN_REL_HOST;
         end
         ST_IN_REL_HOST: begin
            op   = OP_REL_HOST;
            st_d = ST_IN_REL_FIFO;
         end
         ST_IN_REL_FIFO: begin
            op   = OP_REL_FIFO;
            st_d = ST_IN_IRQ;
         end
         ST_IN_IRQ: begin
            op   = OP_IRQ;
            st_d = ST_IN_THR;
         end
         ST_IN_THR: begin
            op   = OP_THR;
            st_d = ST_FINISH;
         end
         ST_CL_ZERO: begin
            op   = OP_ZERO;
            st_d = ST_FINISH;
         end
         ST_FINISH: st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   assign busy = (st_q != ST_IDLE);
   assign done = (st_q == ST_FINISH);

endmodule

// File: rtl/adapter_bringup_seq.sv
module adapter_bringup_seq #(
   parameter int TICKS_PER_UNIT = 4,
   parameter int WAIT_UNITS     = 100,
   parameter int THR_W          = 8,
   parameter int THR_VAL        = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_enable,
   input  logic             cmd_init,
   input  logic             cmd_close,
   output logic             busy,
   output logic             done,
   output logic [2:0]       rst_reg,
   output logic [1:0]       irq_en,
   output logic [THR_W-1:0] fifo_thr
);
   import brs_pkg::*;

   generate
      if (TICKS_PER_UNIT < 1) begin : g_bad_ticks
         $error("TICKS_PER_UNIT must be at least 1");
      end
      if (WAIT_UNITS < 1) begin : g_bad_units
         $error("WAIT_UNITS must be at least 1");
      end
      if (THR_W < 1 || THR_VAL < 0 || THR_VAL >= (1 << THR_W)) begin : g_bad_thr
         $error("THR_VAL must fit in THR_W bits");
      end
   endgenerate

   reg_op_t op;
   logic    run;
   logic    expire;

   brs_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_enable (cmd_enable),
      .cmd_init   (cmd_init),
      .cmd_close  (cmd_close),
      .expire     (expire),
      .op         (op),
      .run        (run),
      .busy       (busy),
      .done       (done)
   );

   brs_wait_timer #(
      .TICKS_PER_UNIT (TICKS_PER_UNIT),
      .WAIT_UNITS     (WAIT_UNITS)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .expire (expire)
   );

   brs_ctrl_regs #(
      .THR_W   (THR_W),
      .THR_VAL (THR_VAL)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .rst_q (rst_reg),
      .irq_q (irq_en),
      .thr_q (fifo_thr)
   );

endmodule

// File: rtl/adapter_bringup_chk.sv
module adapter_bringup_chk #(
   parameter int THR_W   = 8,
   parameter int THR_VAL = 30
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic [2:0]       rst_reg,
   input logic [1:0]       irq_en,
   input logic [THR_W-1:0] fifo_thr
);
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r3_clear_together: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_reg[0]) |-> (rst_reg == 3'b000));

   a_r5_host_after_core: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_reg[1]) |-> (rst_reg == 3'b011));

   a_r5_fifo_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_reg[2]) |-> (rst_reg == 3'b111));

   a_r6_irq_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq_en) |-> (rst_reg == 3'b111 && irq_en == 2'b11));

   a_r7_thr_value: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fifo_thr) |-> (fifo_thr == THR_W'(THR_VAL) && irq_en == 2'b11));

   a_r9_idle_rst_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rst_reg) |-> $past(busy));

   a_r9_idle_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(irq_en) || !$stable(fifo_thr)) |-> $past(busy));

endmodule

bind adapter_bringup_seq adapter_bringup_chk #(
   .THR_W   (THR_W),
   .THR_VAL (THR_VAL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .rst_reg  (rst_reg),
   .irq_en   (irq_en),
   .fifo_thr (fifo_thr)
);

// File: tb/tb_adapter_bringup_seq.sv
`timescale 1ns/1ps
module tb_adapter_bringup_seq;
   localparam int TPU   = 4;
   localparam int UNITS = 100;
   localparam int W     = TPU * UNITS;
   localparam int THR_W = 8;
   localparam int THRV  = 30;
   localparam int LIMIT = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_enable = 1'b0, cmd_init = 1'b0, cmd_close = 1'b0;
   logic busy, done;
   logic [2:0] rst_reg;
   logic [1:0] irq_en;
   logic [THR_W-1:0] fifo_thr;

   always #10 clk = ~clk;

   adapter_bringup_seq #(
      .TICKS_PER_UNIT (TPU),
      .WAIT_UNITS     (UNITS),
      .THR_W          (THR_W),
      .THR_VAL        (THRV)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_enable (cmd_enable),
      .cmd_init   (cmd_init),
      .cmd_close  (cmd_close),
      .busy       (busy),
      .done       (done),
      .rst_reg    (rst_reg),
      .irq_en     (irq_en),
      .fifo_thr   (fifo_thr)
   );

   typedef struct {
      int         start;
      int         lat;
      logic [2:0] rst;
      logic [1:0] irq;
      logic [7:0] thr;
      int         n;
      logic [2:0] tr [6];
      bit         is_init;
      string      req;
   } exp_t;

   exp_t exp_q [$];

   int total = 0;
   int bad = 0;
   int cyc = 0;

   logic [2:0] m_rst = '0;
   logic [1:0] m_irq = '0;
   logic [7:0] m_thr = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic void push_tr(ref exp_t e, ref logic [2:0] prev, input logic [2:0] v);
      if (v != prev) begin
         e.tr[e.n] = v;
         e.n++;
         prev = v;
      end
   endfunction

   // Driver: arbitrates like R11, builds the expected item, pulses the inputs
   task automatic issue(input bit en, input bit in, input bit cl, input string req);
      exp_t e;
      logic [2:0] p;
      e.n = 0;
      e.is_init = 0;
      e.req = req;
      p = m_rst;
      if (cl) begin
         push_tr(e, p, 3'b000);
         e.lat = 2;
      end else if (in) begin
         push_tr(e, p, p | 3'b001);
         push_tr(e, p, 3'b000);
         push_tr(e, p, 3'b001);
         push_tr(e, p, 3'b011);
         push_tr(e, p, 3'b111);
         m_irq = 2'b11;
         m_thr = 8'(THRV);
         e.lat = W + 8;
         e.is_init = 1;
      end else begin
         push_tr(e, p, p | 3'b001);
         e.lat = W + 2;
      end
      m_rst = p;
      e.rst = m_rst;
      e.irq = m_irq;
      e.thr = m_thr;
      @(negedge clk);
      cmd_enable = en;
      cmd_init   = in;
      cmd_close  = cl;
      e.start = cyc;
      exp_q.push_back(e);
      @(negedge clk);
      cmd_enable = 1'b0;
      cmd_init   = 1'b0;
      cmd_close  = 1'b0;
      check(busy === 1'b1, "R10", "busy after accept", int'(busy), 1);
   endtask

   task automatic poke(input bit en, input bit in, input bit cl);
      @(negedge clk);
      cmd_enable = en;
      cmd_init   = in;
      cmd_close  = cl;
      @(negedge clk);
      cmd_enable = 1'b0;
      cmd_init   = 1'b0;
      cmd_close  = 1'b0;
   endtask

   task automatic settle();
      wait (exp_q.size() == 0);
      repeat (4) @(negedge clk);
   endtask

   // Monitor: records reset-register history, pops and compares at done
   logic [2:0] a_val [16];
   int         a_time [16];
   int         a_n = 0;
   logic [2:0] last_rst = '0;
   logic       prev_done = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rst_reg !== last_rst) begin
            if (a_n < 16) begin
               a_val[a_n] = rst_reg;
               a_time[a_n] = cyc;
            end
            a_n++;
            last_rst = rst_reg;
         end
         if (prev_done && done)
            check(1'b0, "R10", "done longer than one cycle", 1, 0);
         if (done && !prev_done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "done without accepted command", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(cyc - e.start == e.lat, e.req, "done latency", cyc - e.start, e.lat);
               check(rst_reg == e.rst, e.req, "rst_reg", int'(rst_reg), int'(e.rst));
               check(irq_en == e.irq, e.req, "irq_en", int'(irq_en), int'(e.irq));
               check(fifo_thr == e.thr, e.req, "fifo_thr", int'(fifo_thr), int'(e.thr));
               check(a_n == e.n, e.req, "reset update count", a_n, e.n);
               if (a_n == e.n) begin
                  for (int i = 0; i < e.n; i++)
                     check(a_val[i] == e.tr[i], e.req, "reset update value",
                           int'(a_val[i]), int'(e.tr[i]));
                  if (e.is_init && e.n >= 4) begin
                     // R4: zero held W+1 cycles; R5: releases one cycle apart
                     check(a_time[e.n-3] - a_time[e.n-4] == W + 1, "R4",
                           "cycles held at zero", a_time[e.n-3] - a_time[e.n-4], W + 1);
                     check(a_time[e.n-2] - a_time[e.n-3] == 1, "R5",
                           "core to host spacing", a_time[e.n-2] - a_time[e.n-3], 1);
                     check(a_time[e.n-1] - a_time[e.n-2] == 1, "R5",
                           "host to fifo spacing", a_time[e.n-1] - a_time[e.n-2], 1);
                  end
               end
            end
            a_n = 0;
         end
         prev_done = done;
      end
   end

   initial begin
      wait (cyc >= LIMIT);
      check(1'b0, "watchdog", "run did not finish", cyc, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(rst_reg == 3'b000 && irq_en == 2'b00 && fifo_thr == '0, "R1",
            "registers in reset", int'({fifo_thr, irq_en, rst_reg}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset",
            int'({busy, done}), 0);
      check(rst_reg == 3'b000, "R1", "rst_reg after reset", int'(rst_reg), 0);

      issue(1, 0, 0, "R2");            // enable from all-reset
      settle();
      issue(0, 0, 1, "R8");            // close
      settle();
      issue(0, 1, 0, "R3");            // init from all-reset, R3..R7
      settle();
      issue(1, 0, 0, "R2");            // enable with host and FIFO released
      settle();
      issue(0, 1, 0, "R7");            // init from fully released
      repeat (20) @(negedge clk);
      poke(1, 0, 0);                   // R9: ignored while busy
      repeat (50) @(negedge clk);
      poke(0, 0, 1);                   // R9: ignored while busy
      settle();
      repeat (30) @(negedge clk);
      check(rst_reg == 3'b111, "R9", "rst_reg after ignored pulses", int'(rst_reg), 7);
      issue(0, 0, 1, "R8");            // close keeps irq/thr
      settle();
      issue(1, 1, 1, "R11");           // close wins
      settle();
      issue(1, 1, 0, "R11");           // init wins over enable
      settle();
      repeat (10) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule